// File: doc/BRIEF.md
# Four-Channel Converter Parallel Register Front End

This block sits between a parallel host bus and four converter channels. A host write is a chip-select window with a low pulse on the write strobe; the block takes the write when the strobe returns high. A mode pin sends the write either to the control side or to the data side. A two-bit address names the channel. On the control side, bus bit 0 picks between one shared system register and the addressed channel's own control register. On the data side, the word loads the channel's input register. It can load a 10-bit main code or an 8-bit sub code, and it can load the word all at once or as two byte-wide parts.

Every channel is double buffered. Input registers collect writes. A load strobe copies all four input registers to the output codes together. Clear requests put both register stages of a channel back to a coding-dependent value. The main path clears to zero under binary coding and to midscale under twos complement coding. The sub path always clears to midscale.

The host bus has no back-pressure. Every qualified write is accepted. The host must not start a new write until the current write strobe has risen again. All bus inputs are synchronous to `clk`.

Top module: `dac_bus_regs`

## Requirements
- R1: A write is taken in the clock cycle in which `wr_n` is first seen high after being low, while `cs_n` is low. The registers update at the end of that cycle. A strobe pulse while `cs_n` is high changes nothing.
- R2: With `mode` low and `db[0]` = 0, the write goes to the system register. With `mode` low and `db[0]` = 1, it goes to the control register of channel `addr` (0 to 3). The system fields are: DB9 byte mode, DB8 twos complement, DB7 power down, DB6 system standby, DB5 system clear. The channel fields are: DB9:DB8 mux select (output on `mux_sel[2c+1:2c]`), DB7 sub target, DB6 channel standby, DB5 channel clear.
- R3: In 10-bit mode, a data write (`mode` high) loads `db[9:0]` into the main input register when the channel's sub-target bit is 0. When that bit is 1, it loads `db[9:2]` into the sub input register, and `db[1:0]` are ignored.
- R4: In byte mode with `db[0]` = 0, the write goes to the main input register. If `db[1]` = 0, `db[9:2]` replace the upper eight bits. If `db[1]` = 1, `db[3:2]` replace the two low bits. The other bits of the register are kept.
- R5: In byte mode with `db[0]` = 1, `db[9:2]` load the sub input register, whatever the sub-target bit holds.
- R6: The output codes change only at a clock edge where `load` is high or a clear is applied. A load copies all four channels at once.
- R7: When a data write and `load` occur in the same cycle, the output code takes the newly written value at that edge.
- R8: A clear sets both the input and the output register of a channel, one cycle after the control write that requests it. The main code becomes 0x000 under binary coding and 0x200 under twos complement coding. The sub code becomes 0x80.
- R9: A system clear clears every channel. A channel clear clears only its own channel. Both clear bits drop by themselves, so later writes and loads act normally.
- R10: `stby[c]` is the OR of the system standby bit and channel c's standby bit. `pwr_down` follows the system power-down bit.
- R11: After reset, all control bits are 0 (10-bit mode, binary coding). Every main code is 0x000 and every sub code is 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; the write is taken on its rise |
| mode | input | 1 | 0 selects control registers, 1 selects data registers |
| addr | input | 2 | Channel address |
| db | input | 10 | Parallel data bus |
| load | input | 1 | Copies all input registers to the output codes |
| main_code | output | 40 | Main output codes; channel c at [10c+9:10c] |
| sub_code | output | 32 | Sub output codes; channel c at [8c+7:8c] |
| pwr_down | output | 1 | Power-down flag |
| stby | output | 4 | Effective standby flag per channel |
| mux_sel | output | 8 | Mux select field per channel; channel c at [2c+1:2c] |

## Verification
A data write and a load can land in the same clock cycle. The bench provokes this by raising `load` at the same moment it releases the write strobe. The channel written must show the new word right after that edge, rather than the input value from before the write. The other channels must reload with their unchanged inputs. A clear and the next write are also placed close together, to show that the self-dropping clear bit does not swallow a later write or load.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int CFG_W = 5;
  localparam int F_SYS_BYTE = 4;
  localparam int F_SYS_TWOS = 3;
  localparam int F_SYS_PD   = 2;
  localparam int F_SYS_STBY = 1;
  localparam int F_CLR      = 0;
  localparam int F_CH_MX_LO = 3;
  localparam int F_CH_SUB   = 2;
  localparam int F_CH_STBY  = 1;

  typedef struct packed {
    logic byte_mode;
    logic twos;
    logic pwr_down;
    logic stby;
  } sys_ctrl_t;

  typedef struct packed {
    logic [1:0] mx;
    logic       sub_tgt;
    logic       stby;
  } ch_ctrl_t;
endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode #(
  parameter int NCH = 4,
  parameter int AW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           wr_n,
  input  logic           mode,
  input  logic [AW-1:0]  addr,
  input  logic           db0,
  output logic           sys_we,
  output logic [NCH-1:0] ch_we,
  output logic [NCH-1:0] dat_we
);
  logic wr_q;
  logic wr_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end

  assign wr_rise = wr_n & ~wr_q & ~cs_n;
  assign sys_we  = wr_rise & ~mode & ~db0;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    logic hit;
    assign hit       = (addr == AW'(i));
    assign ch_we[i]  = wr_rise & ~mode & db0 & hit;
    assign dat_we[i] = wr_rise & mode & hit;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sys_we, ch_we, dat_we})); // R2
  AST_CS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !(sys_we || (|ch_we) || (|dat_we))); // R1
  AST_SINGLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dat_we) |=> !(|dat_we)); // R1
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dacreg_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_we,
  input  logic [NCH-1:0]   ch_we,
  input  logic [CFG_W-1:0] fld,
  output logic             byte_mode,
  output logic             twos,
  output logic             pwr_down,
  output logic [NCH-1:0]   stby_eff,
  output logic [2*NCH-1:0] mx,
  output logic [NCH-1:0]   sub_tgt,
  output logic [NCH-1:0]   clr_ch
);
  sys_ctrl_t      sys_q;
  logic           sys_clr_q;
  ch_ctrl_t       ch_q [NCH];
  logic [NCH-1:0] ch_clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q     <= '0;
      sys_clr_q <= 1'b0;
    end else begin
      sys_clr_q <= sys_we & fld[F_CLR];
      if (sys_we) begin
        sys_q.byte_mode <= fld[F_SYS_BYTE];
        sys_q.twos      <= fld[F_SYS_TWOS];
        sys_q.pwr_down  <= fld[F_SYS_PD];
        sys_q.stby      <= fld[F_SYS_STBY];
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_q[i]     <= '0;
        ch_clr_q[i] <= 1'b0;
      end else begin
        ch_clr_q[i] <= ch_we[i] & fld[F_CLR];
        if (ch_we[i]) begin
          ch_q[i].mx      <= fld[F_CH_MX_LO +: 2];
          ch_q[i].sub_tgt <= fld[F_CH_SUB];
          ch_q[i].stby    <= fld[F_CH_STBY];
        end
      end
    end
    assign stby_eff[i]   = sys_q.stby | ch_q[i].stby;
    assign mx[2*i +: 2]  = ch_q[i].mx;
    assign sub_tgt[i]    = ch_q[i].sub_tgt;
    assign clr_ch[i]     = sys_clr_q | ch_clr_q[i];

    AST_CH_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_clr_q[i] |=> !ch_clr_q[i]); // R9
  end

  assign byte_mode = sys_q.byte_mode;
  assign twos      = sys_q.twos;
  assign pwr_down  = sys_q.pwr_down;

  AST_SYS_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clr_q |=> !sys_clr_q); // R9
  AST_SYS_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clr_q |-> (&clr_ch)); // R9
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int MAIN_W = 10,
  parameter int SUB_W  = MAIN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MAIN_W-1:0] data,
  input  logic              byte_mode,
  input  logic              sub_tgt,
  input  logic              twos,
  input  logic              clr,
  input  logic              load,
  output logic [MAIN_W-1:0] main_o,
  output logic [SUB_W-1:0]  sub_o
);
  localparam logic [MAIN_W-1:0] M_MID = {1'b1, {(MAIN_W-1){1'b0}}};
  localparam logic [SUB_W-1:0]  S_MID = {1'b1, {(SUB_W-1){1'b0}}};

  logic [MAIN_W-1:0] m_in, m_nxt, m_clr;
  logic [SUB_W-1:0]  s_in, s_nxt;

  assign m_clr = twos ? M_MID : '0;

  always_comb begin
    m_nxt = m_in;
    s_nxt = s_in;
    if (we) begin
      if (!byte_mode) begin
        if (sub_tgt) s_nxt = data[MAIN_W-1:2];
        else         m_nxt = data;
      end else if (data[0]) begin
        s_nxt = data[MAIN_W-1:2];
      end else if (data[1]) begin
        m_nxt[1:0] = data[3:2];
      end else begin
        m_nxt[MAIN_W-1:2] = data[MAIN_W-1:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in   <= '0;
      main_o <= '0;
      s_in   <= S_MID;
      sub_o  <= S_MID;
    end else if (clr) begin
      m_in   <= m_clr;
      main_o <= m_clr;
      s_in   <= S_MID;
      sub_o  <= S_MID;
    end else begin
      m_in <= m_nxt;
      s_in <= s_nxt;
      if (load) begin
        main_o <= m_nxt;
        sub_o  <= s_nxt;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> ($stable(main_o) && $stable(sub_o))); // R6
  AST_CLR_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !twos) |=> (main_o == '0)); // R8
  AST_CLR_TWOS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && twos) |=> (main_o == M_MID)); // R8
  AST_CLR_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sub_o == S_MID)); // R8
  AST_LOAD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr && we && !byte_mode && !sub_tgt) |=> (main_o == $past(data))); // R7
endmodule

// File: rtl/dac_bus_regs.sv
module dac_bus_regs
  import dacreg_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int MAIN_W = 10,
  parameter int AW     = $clog2(NCH),
  parameter int SUB_W  = MAIN_W - 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  wr_n,
  input  logic                  mode,
  input  logic [AW-1:0]         addr,
  input  logic [MAIN_W-1:0]     db,
  input  logic                  load,
  output logic [NCH*MAIN_W-1:0] main_code,
  output logic [NCH*SUB_W-1:0]  sub_code,
  output logic                  pwr_down,
  output logic [NCH-1:0]        stby,
  output logic [2*NCH-1:0]      mux_sel
);
  logic           sys_we;
  logic [NCH-1:0] ch_we, dat_we, sub_tgt, clr_ch;
  logic           byte_mode, twos;

  dac_bus_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .mode(mode),
    .addr(addr), .db0(db[0]), .sys_we(sys_we), .ch_we(ch_we), .dat_we(dat_we)
  );

  dac_ctrl_regs #(.NCH(NCH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sys_we(sys_we), .ch_we(ch_we),
    .fld(db[MAIN_W-1 -: CFG_W]), .byte_mode(byte_mode), .twos(twos),
    .pwr_down(pwr_down), .stby_eff(stby), .mx(mux_sel),
    .sub_tgt(sub_tgt), .clr_ch(clr_ch)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dac_chan #(.MAIN_W(MAIN_W), .SUB_W(SUB_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .we(dat_we[i]), .data(db),
      .byte_mode(byte_mode), .sub_tgt(sub_tgt[i]), .twos(twos),
      .clr(clr_ch[i]), .load(load),
      .main_o(main_code[i*MAIN_W +: MAIN_W]), .sub_o(sub_code[i*SUB_W +: SUB_W])
    );
  end

  AST_STBY_OR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sys_we) && $past(db[MAIN_W-4]) |-> (&stby)); // R10
endmodule

// File: tb/sim_dac_bus_regs.sv
module sim_dac_bus_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, mode = 1'b0, load = 1'b0;
  logic [1:0] addr = '0;
  logic [9:0] db = '0;
  logic [39:0] main_code;
  logic [31:0] sub_code;
  logic pwr_down;
  logic [3:0] stby;
  logic [7:0] mux_sel;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  dac_bus_regs u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .mode(mode),
    .addr(addr), .db(db), .load(load), .main_code(main_code),
    .sub_code(sub_code), .pwr_down(pwr_down), .stby(stby), .mux_sel(mux_sel)
  );

  typedef struct {
    string      req;
    int         ch;
    logic [9:0] m;
    logic [7:0] s;
  } exp_t;

  exp_t sb[$];
  event chk_ev;

  logic [9:0] m_in [4], m_out [4];
  logic [7:0] s_in [4], s_out [4];
  logic       sub_t [4];
  logic       byte_m = 1'b0, twos_m = 1'b0;

  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        total++;
        if (main_code[it.ch*10 +: 10] !== it.m || sub_code[it.ch*8 +: 8] !== it.s) begin
          bad++;
          $display("FAIL %s ch%0d: main=%h sub=%h expected main=%h sub=%h",
                   it.req, it.ch, main_code[it.ch*10 +: 10], sub_code[it.ch*8 +: 8], it.m, it.s);
        end
      end
    end
  end

  task automatic check_all(input string req);
    for (int c = 0; c < 4; c++) sb.push_back('{req, c, m_out[c], s_out[c]});
    -> chk_ev;
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_data(input int c, input logic [9:0] d);
    if (!byte_m) begin
      if (sub_t[c]) s_in[c] = d[9:2];
      else          m_in[c] = d;
    end else if (d[0]) s_in[c] = d[9:2];
    else if (d[1])     m_in[c][1:0] = d[3:2];
    else               m_in[c][9:2] = d[9:2];
  endtask

  task automatic m_load();
    for (int c = 0; c < 4; c++) begin
      m_out[c] = m_in[c];
      s_out[c] = s_in[c];
    end
  endtask

  task automatic m_clear(input int c);
    m_in[c]  = twos_m ? 10'h200 : 10'h000;
    m_out[c] = m_in[c];
    s_in[c]  = 8'h80;
    s_out[c] = 8'h80;
  endtask

  task automatic bus_write(input logic md, input logic [1:0] a, input logic [9:0] d,
                           input logic sel, input logic with_load);
    @(negedge clk);
    cs_n = ~sel; mode = md; addr = a; db = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    if (with_load) load = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; load = 1'b0;
    @(negedge clk);
  endtask

  task automatic data_wr(input int c, input logic [9:0] d);
    bus_write(1'b1, 2'(c), d, 1'b1, 1'b0);
    m_data(c, d);
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    m_load();
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_in[c] = '0; m_out[c] = '0; s_in[c] = 8'h80; s_out[c] = 8'h80; sub_t[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check_all("R11");
    chk("R11 stby", 32'(stby), 32'h0);
    chk("R11 pwr_down", 32'(pwr_down), 32'h0);
    chk("R11 mux_sel", 32'(mux_sel), 32'h0);

    // R3 10-bit main writes, R6 outputs held until load
    data_wr(0, 10'h123); data_wr(1, 10'h2A7); data_wr(2, 10'h05C); data_wr(3, 10'h3E1);
    check_all("R6 held before load");
    pulse_load();
    check_all("R3 R6 load all");

    // R1 write with chip select high is ignored
    bus_write(1'b1, 2'd0, 10'h3FF, 1'b0, 1'b0);
    pulse_load();
    check_all("R1 cs high ignored");

    // R2 channel control: ch2 mx=2, sub target=1
    bus_write(1'b0, 2'd2, 10'h281, 1'b1, 1'b0);
    sub_t[2] = 1'b1;
    chk("R2 mux_sel", 32'(mux_sel), 32'h20);
    chk("R2 stby untouched", 32'(stby), 32'h0);

    // R3 sub write in 10-bit mode, low bits ignored
    data_wr(2, 10'h2CF);
    pulse_load();
    check_all("R3 sub write");

    // R4 byte mode main upper/lower
    bus_write(1'b0, 2'd0, 10'h200, 1'b1, 1'b0);
    byte_m = 1'b1;
    data_wr(1, 10'h294);
    data_wr(1, 10'h00A);
    pulse_load();
    check_all("R4 byte main");
    // R5 byte sub, and sub target ignored in byte mode for ch2
    data_wr(3, 10'h0F1);
    data_wr(2, 10'h044);
    pulse_load();
    check_all("R5 byte sub");

    // R7 write and load in the same cycle
    bus_write(1'b1, 2'd0, 10'h1F8, 1'b1, 1'b1);
    m_data(0, 10'h1F8);
    m_load();
    check_all("R7 write with load");

    // R8 R9 channel clear on ch3, binary coding
    data_wr(3, 10'h3FC);
    bus_write(1'b0, 2'd3, 10'h021, 1'b1, 1'b0);
    sub_t[3] = 1'b0;
    m_clear(3);
    check_all("R8 R9 channel clear");
    pulse_load();
    check_all("R9 clear reached input reg");

    // R9 clear self-drops
    data_wr(3, 10'h0F1);
    pulse_load();
    check_all("R9 self clearing");

    // R8 R9 system clear under twos complement, back to 10-bit mode
    bus_write(1'b0, 2'd0, 10'h120, 1'b1, 1'b0);
    byte_m = 1'b0; twos_m = 1'b1;
    for (int c = 0; c < 4; c++) m_clear(c);
    check_all("R8 R9 system clear twos");

    // R10 standby and power down
    bus_write(1'b0, 2'd1, 10'h041, 1'b1, 1'b0);
    sub_t[1] = 1'b0;
    chk("R10 channel stby", 32'(stby), 32'h2);
    bus_write(1'b0, 2'd0, 10'h1C0, 1'b1, 1'b0);
    chk("R10 system stby", 32'(stby), 32'hF);
    chk("R10 pwr_down on", 32'(pwr_down), 32'h1);
    bus_write(1'b0, 2'd0, 10'h100, 1'b1, 1'b0);
    chk("R10 system stby off", 32'(stby), 32'h2);
    chk("R10 pwr_down off", 32'(pwr_down), 32'h0);

    // R3 10-bit mode again: ch1 main, ch2 still sub target
    data_wr(1, 10'h3FF);
    data_wr(2, 10'h155);
    pulse_load();
    check_all("R3 after mode return");

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule